// File: doc/BRIEF.md
# Double-and-Add Scalar Multiplication Sequencer

This block controls the computation of Q = kP on a binary-field elliptic curve y^2 + xy = x^3 + ax^2 + b (b nonzero, affine coordinates). It scans the scalar k from its top bit down to bit 0. For every bit it doubles Q, and when that bit is 1 it then adds P. The field arithmetic lives in an external point unit. The sequencer drives that unit through a one-cycle request pulse and waits for a completion pulse, so the unit may take any number of cycles per operation.

The sequencer knows when Q is the point at infinity and handles those cases itself. A doubling of infinity is skipped and issues no request. Adding P to infinity just copies P into Q. The external unit therefore never receives infinity as an operand. The unit may still return infinity as a result, for example P + (-P) or a doubling of a point with x = 0, and the sequencer records that in its infinity flag. When the scan ends, the block pulses `done` and keeps the result coordinates and the `is_infinity` flag until the next accepted start.

FSM states:
- ST_IDLE: waiting for start.
- ST_DBL: decide whether to double.
- ST_DWAIT: waiting for a doubling.
- ST_ADD: decide whether to add.
- ST_AWAIT: waiting for an addition.
- ST_NEXT: step to the next bit.
- ST_DONE: pulse `done`.

Transitions:
- IDLE→DBL on start.
- DBL→ADD when Q is infinity.
- DBL→DWAIT when a doubling is issued.
- DWAIT→ADD on unit done.
- ADD→NEXT when the bit is 0, or when the bit is 1 and Q is infinity (P is loaded).
- ADD→AWAIT when an addition is issued.
- AWAIT→NEXT on unit done.
- NEXT→DBL when bits remain.
- NEXT→DONE after bit 0.
- DONE→IDLE always.

Top module: `kmul_seq`

## Requirements
- R1: After reset `busy`, `done` and `op_start` are 0 and `is_infinity` is 1.
- R2: At `done`, (`res_qx`, `res_qy`, `is_infinity`) equals k·P as computed by repeated point addition starting from infinity.
- R3: Bits of k are used from bit SCALAR_W-1 down to bit 0. Each bit first doubles Q, then adds P when the bit is 1. A request with `op_kind` = 0 is a doubling of (`op_ax`,`op_ay`). A request with `op_kind` = 1 is the addition of (`op_ax`,`op_ay`) and (`op_bx`,`op_by`), where (`op_bx`,`op_by`) = P.
- R4: While Q is infinity, a doubling is skipped, Q stays infinity, and no request is issued. The unit is never sent infinity as an operand.
- R5: Adding P when Q is infinity loads P into Q and issues no request.
- R6: When the unit completes with `op_res_inf` = 1, Q becomes infinity, and the later steps follow R4 and R5.
- R7: For k = 0 the result has `is_infinity` = 1, and no request is issued.
- R8: A `start` while `busy` is 1 is ignored. The running computation and its result are unchanged.
- R9: `op_start` is a single-cycle pulse. The operand outputs stay stable from the request until `op_done`, whatever the unit's latency.
- R10: `done` is high for exactly one cycle, after which `busy` is 0. The result outputs hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| scalar_k | input | SCALAR_W | Scalar k |
| base_x | input | COORD_W | x of P |
| base_y | input | COORD_W | y of P |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| is_infinity | output | 1 | Q is the point at infinity |
| res_qx | output | COORD_W | x of Q |
| res_qy | output | COORD_W | y of Q |
| op_start | output | 1 | Request pulse to the point unit |
| op_kind | output | 1 | 0 = double, 1 = add |
| op_ax | output | COORD_W | First operand x (Q) |
| op_ay | output | COORD_W | First operand y (Q) |
| op_bx | output | COORD_W | Second operand x (P) |
| op_by | output | COORD_W | Second operand y (P) |
| op_done | input | 1 | Point unit completion pulse |
| op_res_x | input | COORD_W | Result x from the unit |
| op_res_y | input | COORD_W | Result y from the unit |
| op_res_inf | input | 1 | Unit result is infinity |

## Verification
The bench builds the sequencer with SCALAR_W = 8 and COORD_W = 4. It attaches a behavioural point unit over a 16-element field with a = b = 1. That unit answers each request after a latency that rotates between one and four cycles.

The small field lets the bench find a point of the largest available order and compare every result against exhaustive repeated addition. It also makes the order-2 point (0, 1) available. Doubling that point returns infinity, which exercises the return to infinity in the middle of a scan. The 8-bit scalar makes full scans, k = 0 and the all-ones scalar short, so command counts per operation kind can be checked for each run.

// File: rtl/kmul_pkg.sv
package kmul_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DBL   = 3'd1,
        ST_DWAIT = 3'd2,
        ST_ADD   = 3'd3,
        ST_AWAIT = 3'd4,
        ST_NEXT  = 3'd5,
        ST_DONE  = 3'd6
    } seq_state_e;

    localparam logic OPK_DOUBLE = 1'b0;
    localparam logic OPK_ADD    = 1'b1;
endpackage

// File: rtl/kmul_scan.sv
module kmul_scan #(
    parameter int SCALAR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SCALAR_W-1:0] k_in,
    input  logic                advance,
    output logic                cur_bit,
    output logic                last_bit
);
    localparam int CNT_W = $clog2(SCALAR_W + 1);

    logic [SCALAR_W-1:0] k_sh;
    logic [CNT_W-1:0]    remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_sh   <= '0;
            remain <= '0;
        end else if (load) begin
            k_sh   <= k_in;
            remain <= CNT_W'(SCALAR_W);
        end else if (advance) begin
            k_sh   <= {k_sh[SCALAR_W-2:0], 1'b0};
            remain <= remain - 1'b1;
        end
    end

    assign cur_bit  = k_sh[SCALAR_W-1];
    assign last_bit = (remain == CNT_W'(1));

    // R3
    scan_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (remain != '0));
endmodule

// File: rtl/kmul_qreg.sv
module kmul_qreg #(
    parameter int COORD_W = 233
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_inf,
    input  logic               load_base,
    input  logic               load_res,
    input  logic [COORD_W-1:0] base_x,
    input  logic [COORD_W-1:0] base_y,
    input  logic [COORD_W-1:0] res_x,
    input  logic [COORD_W-1:0] res_y,
    input  logic               res_inf,
    output logic [COORD_W-1:0] q_x,
    output logic [COORD_W-1:0] q_y,
    output logic               q_inf
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_x   <= '0;
            q_y   <= '0;
            q_inf <= 1'b1;
        end else if (set_inf) begin
            q_inf <= 1'b1;
        end else if (load_base) begin
            q_x   <= base_x;
            q_y   <= base_y;
            q_inf <= 1'b0;
        end else if (load_res) begin
            q_x   <= res_x;
            q_y   <= res_y;
            q_inf <= res_inf;
        end
    end

    // R6
    qreg_one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_inf, load_base, load_res}));
endmodule

// File: rtl/kmul_seq.sv
module kmul_seq
    import kmul_pkg::*;
#(
    parameter int SCALAR_W = 233,
    parameter int COORD_W  = 233
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SCALAR_W-1:0] scalar_k,
    input  logic [COORD_W-1:0]  base_x,
    input  logic [COORD_W-1:0]  base_y,
    output logic                busy,
    output logic                done,
    output logic                is_infinity,
    output logic [COORD_W-1:0]  res_qx,
    output logic [COORD_W-1:0]  res_qy,
    output logic                op_start,
    output logic                op_kind,
    output logic [COORD_W-1:0]  op_ax,
    output logic [COORD_W-1:0]  op_ay,
    output logic [COORD_W-1:0]  op_bx,
    output logic [COORD_W-1:0]  op_by,
    input  logic                op_done,
    input  logic [COORD_W-1:0]  op_res_x,
    input  logic [COORD_W-1:0]  op_res_y,
    input  logic                op_res_inf
);
    seq_state_e state, state_nx;

    logic accept, advance, cur_bit, last_bit;
    logic set_inf, load_base, load_res, q_inf;
    logic [COORD_W-1:0] p_x, p_y, q_x, q_y;

    assign accept = start && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_x <= '0;
            p_y <= '0;
        end else if (accept) begin
            p_x <= base_x;
            p_y <= base_y;
        end
    end

    kmul_scan #(.SCALAR_W(SCALAR_W)) scan_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .k_in     (scalar_k),
        .advance  (advance),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    kmul_qreg #(.COORD_W(COORD_W)) qreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_inf   (set_inf),
        .load_base (load_base),
        .load_res  (load_res),
        .base_x    (p_x),
        .base_y    (p_y),
        .res_x     (op_res_x),
        .res_y     (op_res_y),
        .res_inf   (op_res_inf),
        .q_x       (q_x),
        .q_y       (q_y),
        .q_inf     (q_inf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        op_start  = 1'b0;
        op_kind   = OPK_DOUBLE;
        advance   = 1'b0;
        set_inf   = 1'b0;
        load_base = 1'b0;
        load_res  = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    set_inf  = 1'b1;
                    state_nx = ST_DBL;
                end
            end
            ST_DBL: begin
                if (q_inf) begin
                    state_nx = ST_ADD;
                end else begin
                    op_start = 1'b1;
                    state_nx = ST_DWAIT;
                end
            end
            ST_DWAIT: begin
                if (op_done) begin
                    load_res = 1'b1;
                    state_nx = ST_ADD;
                end
            end
            ST_ADD: begin
                op_kind = OPK_ADD;
                if (!cur_bit) begin
                    state_nx = ST_NEXT;
                end else if (q_inf) begin
                    load_base = 1'b1;
                    state_nx  = ST_NEXT;
                end else begin
                    op_start = 1'b1;
                    state_nx = ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                op_kind = OPK_ADD;
                if (op_done) begin
                    load_res = 1'b1;
                    state_nx = ST_NEXT;
                end
            end
            ST_NEXT: begin
                advance  = 1'b1;
                state_nx = last_bit ? ST_DONE : ST_DBL;
            end
            ST_DONE: begin
                done     = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign busy        = (state != ST_IDLE);
    assign is_infinity = q_inf;
    assign res_qx      = q_x;
    assign res_qy      = q_y;
    assign op_ax       = q_x;
    assign op_ay       = q_y;
    assign op_bx       = p_x;
    assign op_by       = p_y;

    // R4
    no_inf_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !is_infinity);

    // R9
    op_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    // R9
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DWAIT || state == ST_AWAIT) && !op_done)
            |=> $stable({op_ax, op_ay, op_bx, op_by}));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);
endmodule

// File: tb/kmul_seq_tb_top.sv
`timescale 1ns/1ps
module kmul_seq_tb_top;
    localparam int SW = 8;
    localparam int CW = 4;

    typedef struct packed {
        logic          inf;
        logic [CW-1:0] x;
        logic [CW-1:0] y;
    } pt_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic start = 1'b0;
    logic [SW-1:0] scalar_k = '0;
    logic [CW-1:0] base_x = '0, base_y = '0;
    logic busy, done, is_infinity, op_start, op_kind;
    logic [CW-1:0] res_qx, res_qy, op_ax, op_ay, op_bx, op_by;
    logic op_done = 1'b0, op_res_inf = 1'b0;
    logic [CW-1:0] op_res_x = '0, op_res_y = '0;

    kmul_seq #(.SCALAR_W(SW), .COORD_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .scalar_k(scalar_k),
        .base_x(base_x), .base_y(base_y), .busy(busy), .done(done),
        .is_infinity(is_infinity), .res_qx(res_qx), .res_qy(res_qy),
        .op_start(op_start), .op_kind(op_kind), .op_ax(op_ax), .op_ay(op_ay),
        .op_bx(op_bx), .op_by(op_by), .op_done(op_done), .op_res_x(op_res_x),
        .op_res_y(op_res_y), .op_res_inf(op_res_inf)
    );

    int n_checks = 0, n_errors = 0;
    int n_dbl = 0, n_add = 0, n_hold_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // GF(2^4), modulus x^4+x+1, curve a=1 b=1
    function automatic logic [CW-1:0] gmul(input logic [CW-1:0] a, input logic [CW-1:0] b);
        logic [CW-1:0] r = '0, s = a;
        for (int i = 0; i < CW; i++) begin
            if (b[i]) r = r ^ s;
            s = s[CW-1] ? ((s << 1) ^ 4'h3) : (s << 1);
        end
        return r;
    endfunction

    function automatic logic [CW-1:0] ginv(input logic [CW-1:0] a);
        logic [CW-1:0] r = 4'h1;
        for (int i = 0; i < 14; i++) r = gmul(r, a);
        return r;
    endfunction

    function automatic pt_t pdbl(input pt_t p);
        pt_t r;
        logic [CW-1:0] l;
        if (p.inf || p.x == '0) return '{inf: 1'b1, x: '0, y: '0};
        l = p.x ^ gmul(p.y, ginv(p.x));
        r.inf = 1'b0;
        r.x = gmul(l, l) ^ l ^ 4'h1;
        r.y = gmul(p.x, p.x) ^ gmul(l ^ 4'h1, r.x);
        return r;
    endfunction

    function automatic pt_t padd(input pt_t p, input pt_t q);
        pt_t r;
        logic [CW-1:0] l;
        if (p.inf) return q;
        if (q.inf) return p;
        if (p.x == q.x && p.y == q.y) return pdbl(p);
        if (p.x == q.x) return '{inf: 1'b1, x: '0, y: '0};
        l = gmul(p.y ^ q.y, ginv(p.x ^ q.x));
        r.inf = 1'b0;
        r.x = gmul(l, l) ^ l ^ p.x ^ q.x ^ 4'h1;
        r.y = gmul(l, p.x ^ r.x) ^ r.x ^ p.y;
        return r;
    endfunction

    // behavioural point unit with rotating latency 1..4 cycles
    int lat_sel = 0;
    int lat_left = 0;
    pt_t pend;
    logic [4*CW-1:0] cap_ops;
    always @(posedge clk) begin
        op_done <= 1'b0;
        if (op_start) begin
            if (op_kind) begin
                n_add++;
                pend = padd('{inf: 1'b0, x: op_ax, y: op_ay}, '{inf: 1'b0, x: op_bx, y: op_by});
            end else begin
                n_dbl++;
                pend = pdbl('{inf: 1'b0, x: op_ax, y: op_ay});
            end
            cap_ops = {op_ax, op_ay, op_bx, op_by};
            lat_sel = (lat_sel + 1) % 4;
            lat_left = lat_sel + 1;
        end else if (lat_left > 0) begin
            if ({op_ax, op_ay, op_bx, op_by} != cap_ops) n_hold_err++;
            lat_left = lat_left - 1;
            if (lat_left == 0) begin
                op_done    <= 1'b1;
                op_res_x   <= pend.x;
                op_res_y   <= pend.y;
                op_res_inf <= pend.inf;
            end
        end
    end

    function automatic pt_t ref_mul(input int k, input pt_t p);
        pt_t q = '{inf: 1'b1, x: '0, y: '0};
        for (int i = 0; i < k; i++) q = padd(q, p);
        return q;
    endfunction

    // expected request counts from the double-and-add rules
    task automatic ref_counts(input int k, input pt_t p, output int ed, output int ea);
        pt_t q = '{inf: 1'b1, x: '0, y: '0};
        ed = 0; ea = 0;
        for (int i = SW - 1; i >= 0; i--) begin
            if (!q.inf) ed++;
            q = pdbl(q);
            if (k[i]) begin
                if (!q.inf) ea++;
                q = padd(q, p);
            end
        end
    endtask

    pt_t gen;
    pt_t ord2 = '{inf: 1'b0, x: 4'h0, y: 4'h1};

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    task automatic run_k(input int k, input pt_t p, input string tag);
        pt_t e;
        int ed, ea;
        bit ok;
        n_dbl = 0; n_add = 0; n_hold_err = 0;
        @(negedge clk);
        scalar_k = k[SW-1:0]; base_x = p.x; base_y = p.y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk(ok, {tag, " R10 done seen"}, ok, 1);
        e = ref_mul(k, p);
        ref_counts(k, p, ed, ea);
        chk(is_infinity == e.inf, {tag, " R2 inf"}, is_infinity, e.inf);
        if (!e.inf)
            chk({res_qx, res_qy} == {e.x, e.y}, {tag, " R2 point"}, {res_qx, res_qy}, {e.x, e.y});
        chk(n_dbl == ed, {tag, " R3/R4 doublings"}, n_dbl, ed);
        chk(n_add == ea, {tag, " R3/R5 additions"}, n_add, ea);
        chk(n_hold_err == 0, {tag, " R9 operand hold"}, n_hold_err, 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0 && done == 1'b0 && op_start == 1'b0, "R1 idle outputs",
            {busy, done, op_start}, 0);
        chk(is_infinity == 1'b1, "R1 infinity", is_infinity, 1);
    endtask

    task automatic t_sweep();
        int ks[7] = '{1, 2, 3, 5, 8'h80, 8'hA5, 8'hFF};
        foreach (ks[i]) run_k(ks[i], gen, $sformatf("sweep k=%0h", ks[i]));
    endtask

    task automatic t_zero();
        run_k(0, gen, "R7 k=0");
        chk(is_infinity == 1'b1, "R7 zero gives infinity", is_infinity, 1);
        chk(n_dbl + n_add == 0, "R7 no requests", n_dbl + n_add, 0);
    endtask

    task automatic t_order2();
        run_k(2, ord2, "R6 order2 k=2");
        run_k(3, ord2, "R6 order2 k=3");
        run_k(8'hB7, ord2, "R6 order2 k=b7");
    endtask

    task automatic t_busy_ignore();
        pt_t e;
        bit ok;
        @(negedge clk);
        scalar_k = 8'h6D; base_x = gen.x; base_y = gen.y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        scalar_k = 8'h13; base_x = ord2.x; base_y = ord2.y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        e = ref_mul(8'h6D, gen);
        chk(ok && is_infinity == e.inf && {res_qx, res_qy} == {e.x, e.y},
            "R8 start during busy ignored", {is_infinity, res_qx, res_qy}, {e.inf, e.x, e.y});
    endtask

    task automatic t_hold();
        logic [2*CW:0] snap;
        run_k(8'h37, gen, "R10 hold run");
        snap = {is_infinity, res_qx, res_qy};
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 done one cycle", {done, busy}, 0);
        repeat (5) @(negedge clk);
        chk({is_infinity, res_qx, res_qy} == snap, "R10 result held", {is_infinity, res_qx, res_qy}, snap);
    endtask

    bit finished = 1'b0;
    initial begin
        #(5 * 150000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int best = 0;
        gen = '{inf: 1'b0, x: '0, y: '0};
        for (int x = 1; x < 16; x++)
            for (int y = 0; y < 16; y++) begin
                pt_t c, q;
                int ord;
                logic [CW-1:0] lx = x[CW-1:0], ly = y[CW-1:0];
                if ((gmul(ly, ly) ^ gmul(lx, ly)) ==
                    (gmul(gmul(lx, lx), lx) ^ gmul(lx, lx) ^ 4'h1)) begin
                    c = '{inf: 1'b0, x: lx, y: ly};
                    q = c; ord = 1;
                    while (!q.inf && ord < 40) begin q = padd(q, c); ord++; end
                    if (ord > best) begin best = ord; gen = c; end
                end
            end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_zero();
        t_order2();
        t_busy_ignore();
        t_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule